// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master with Slave Clock-Hold Tolerance

This block is the bit-level engine of a two-wire serial bus master. A local controller hands it one command at a time (start condition, write a byte, read a byte, stop condition). The engine forms the matching waveform on the clock and data lines and pulses `done` when the command is complete. Both lines are open-drain. The engine only ever enables a pull-down, and it observes each line through a two-flop synchronizer.

A slave may hold the clock low to slow the transfer. Each time the engine lets the clock go, it waits for the synchronized line to read high before it times the high phase. The wait is bounded: if the line stays low for more than `STRETCH_MAX` microsecond-equivalent ticks, the engine gives up, releases both lines and raises `stretch_err`. For written bytes, after the acknowledge clock has risen, the engine holds the clock high for `SETTLE_US` ticks and then polls the data line for the slave's acknowledge. If no acknowledge arrives within `ACK_MAX` ticks, it sends a stop condition itself and raises `ack_err`. With `hs_mode` set, the clock is read back only at the acknowledge position, because that is the only place where holding is allowed in that mode.

Top module: `i2c_stretch_master`

## Requirements
- R1: After releasing the clock, the engine does not begin a high phase while the synchronized clock reads low. It starts the high-phase timing only once the line is seen high.
- R2: Both lines are driven only as pull-down enables (`scl_oe`, `sda_oe`; 1 = pull low). After reset both enables are 0, and `busy` and `done` are 0.
- R3: If a clock hold outlasts `STRETCH_MAX` microsecond ticks, the engine releases both lines, sets `stretch_err`, leaves `ack_err` clear and pulses `done`.
- R4: On a written byte's acknowledge bit, the clock stays released for at least `SETTLE_US` microsecond ticks after the line goes high, before the engine can sample the acknowledge and pull the clock low.
- R5: If the data line is still high `ACK_MAX` microsecond ticks after the settle interval, the engine forms a stop condition, sets `ack_err` and pulses `done` when the stop is complete.
- R6: With `hs_mode` = 1, a clock hold at the acknowledge position is still waited out without error.
- R7: On a write, `sda_oe` is 0 during the acknowledge bit. On a read, the engine drives the acknowledge bit low when `rd_nack` = 0 and leaves it high when `rd_nack` = 1.
- R8: Written bytes go out most significant bit first. During data bits, `sda_oe` changes only while the engine pulls the clock low.
- R9: Read bytes are sampled most significant bit first on each clock high phase. The result appears on `rd_byte` when `done` pulses.
- R10: Every clock high phase lasts at least two quarter-bit periods (`2*QTR_DIV` cycles).
- R11: `cmd` encodes 0 = start, 1 = write, 2 = read, 3 = stop, and is accepted with `cmd_valid` while `busy` = 0. Both error flags clear when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, taken while idle |
| cmd | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| wr_byte | input | 8 | Byte to write |
| rd_nack | input | 1 | Acknowledge level to send after a read (1 = not acknowledged) |
| hs_mode | input | 1 | Read back the clock only at the acknowledge position |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | Pull the clock line low |
| sda_oe | output | 1 | Pull the data line low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at command completion |
| rd_byte | output | 8 | Last byte shifted in |
| ack_err | output | 1 | No acknowledge; a stop was issued |
| stretch_err | output | 1 | Clock hold exceeded its limit |

## Verification
The assertions assume that commands arrive only while the engine is idle and that the line inputs are the open-drain wired-AND of the engine's own enables and a slave. The slave may pull a line low but never forces it high while the engine pulls it low. The bench's slave model follows the protocol. It changes the data line only on clock falling edges, and it holds the clock only at the acknowledge position, for a set number of cycles. Once a transfer ends, it drops every pull-down before the next start, so no unprotocol-like state reaches the engine.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_STOP  = 2'd3
    } cmd_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ST_REL, S_ST_HI, S_ST_LO,
        S_B_LO, S_RISE, S_B_HI, S_ACK_SET, S_ACK_W,
        S_SP_LO, S_SP_HI, S_SP_END
    } state_e;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int QTR_DIV     = 312,
    parameter int US_DIV      = 125,
    parameter int STRETCH_MAX = 1000,
    parameter int SETTLE_US   = 10,
    parameter int ACK_MAX     = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic [7:0] wr_byte,
    input  logic       rd_nack,
    input  logic       hs_mode,
    input  logic       scl_s,
    input  logic       sda_s,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic       ack_err,
    output logic       stretch_err
);
    localparam int CMAX = (STRETCH_MAX > ACK_MAX) ?
                          ((STRETCH_MAX > SETTLE_US) ? STRETCH_MAX : SETTLE_US) :
                          ((ACK_MAX > SETTLE_US) ? ACK_MAX : SETTLE_US);
    localparam int UW = $clog2(CMAX + 2);
    localparam logic [UW-1:0] STR_LIM = UW'(STRETCH_MAX);
    localparam logic [UW-1:0] ACK_LIM = UW'(ACK_MAX);
    localparam logic [UW-1:0] SET_LIM = UW'(SETTLE_US - 1);

    typedef struct packed {
        state_e        st;
        state_e        ret;
        logic          chk;
        logic          scl_oe;
        logic          sda_oe;
        logic [7:0]    sr;
        logic [3:0]    bitn;
        logic          qc;
        logic [UW-1:0] uc;
        logic          wr_op;
        logic          nack;
        logic          done;
        logic          ack_err;
        logic          str_err;
    } eng_t;

    eng_t n, q;
    logic qtick, utick, clr;

    i2cm_tick #(.DIV(QTR_DIV)) u_qtick (.clk(clk), .rst_n(rst_n), .clr(clr), .tick(qtick));
    i2cm_tick #(.DIV(US_DIV))  u_utick (.clk(clk), .rst_n(rst_n), .clr(clr), .tick(utick));

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (qtick) n.qc = ~q.qc;
        unique case (q.st)
            S_IDLE: if (cmd_valid) begin
                n.ack_err = 1'b0;
                n.str_err = 1'b0;
                n.nack    = rd_nack;
                n.bitn    = '0;
                case (cmd_e'(cmd))
                    CMD_START: begin n.sda_oe = 1'b0; n.st = S_ST_REL; end
                    CMD_WRITE: begin n.sr = wr_byte; n.wr_op = 1'b1; n.scl_oe = 1'b1; n.st = S_B_LO; end
                    CMD_READ:  begin n.sr = '0; n.wr_op = 1'b0; n.scl_oe = 1'b1; n.st = S_B_LO; end
                    default:   begin n.scl_oe = 1'b1; n.st = S_SP_LO; end
                endcase
            end
            S_ST_REL: if (qtick && q.qc) begin
                n.scl_oe = 1'b0;
                n.chk    = !hs_mode;
                n.ret    = S_ST_HI;
                n.st     = S_RISE;
            end
            S_ST_HI: if (qtick && q.qc) begin
                n.sda_oe = 1'b1;
                n.st     = S_ST_LO;
            end
            S_ST_LO: if (qtick && q.qc) begin
                n.scl_oe = 1'b1;
                n.done   = 1'b1;
                n.st     = S_IDLE;
            end
            S_B_LO: if (qtick) begin
                if (!q.qc) begin
                    if (q.bitn[3]) n.sda_oe = q.wr_op ? 1'b0 : !q.nack;
                    else           n.sda_oe = q.wr_op ? !q.sr[7] : 1'b0;
                end else begin
                    n.scl_oe = 1'b0;
                    n.chk    = !hs_mode || q.bitn[3];
                    n.ret    = (q.bitn[3] && q.wr_op) ? S_ACK_SET : S_B_HI;
                    n.st     = S_RISE;
                end
            end
            S_RISE: begin
                if (!q.chk || scl_s) begin
                    n.st = q.ret;
                end else if (utick) begin
                    if (q.uc >= STR_LIM) begin
                        n.scl_oe  = 1'b0;
                        n.sda_oe  = 1'b0;
                        n.str_err = 1'b1;
                        n.done    = 1'b1;
                        n.st      = S_IDLE;
                    end else begin
                        n.uc = q.uc + 1'b1;
                    end
                end
            end
            S_B_HI: if (qtick && q.qc) begin
                n.scl_oe = 1'b1;
                if (!q.bitn[3]) begin
                    n.sr   = {q.sr[6:0], sda_s};
                    n.bitn = q.bitn + 4'd1;
                    n.st   = S_B_LO;
                end else begin
                    n.done = 1'b1;
                    n.st   = S_IDLE;
                end
            end
            S_ACK_SET: if (utick) begin
                if (q.uc >= SET_LIM) n.st = S_ACK_W;
                else                 n.uc = q.uc + 1'b1;
            end
            S_ACK_W: begin
                if (!sda_s) begin
                    n.scl_oe = 1'b1;
                    n.done   = 1'b1;
                    n.st     = S_IDLE;
                end else if (utick) begin
                    if (q.uc >= ACK_LIM) begin
                        n.ack_err = 1'b1;
                        n.scl_oe  = 1'b1;
                        n.st      = S_SP_LO;
                    end else begin
                        n.uc = q.uc + 1'b1;
                    end
                end
            end
            S_SP_LO: if (qtick) begin
                if (!q.qc) begin
                    n.sda_oe = 1'b1;
                end else begin
                    n.scl_oe = 1'b0;
                    n.chk    = !hs_mode;
                    n.ret    = S_SP_HI;
                    n.st     = S_RISE;
                end
            end
            S_SP_HI: if (qtick && q.qc) begin
                n.sda_oe = 1'b0;
                n.st     = S_SP_END;
            end
            S_SP_END: if (qtick && q.qc) begin
                n.done = 1'b1;
                n.st   = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase
        if (n.st != q.st) begin
            n.qc = 1'b0;
            n.uc = '0;
        end
    end

    assign clr = (n.st != q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign scl_oe      = q.scl_oe;
    assign sda_oe      = q.sda_oe;
    assign busy        = (q.st != S_IDLE);
    assign done        = q.done;
    assign rd_byte     = q.sr;
    assign ack_err     = q.ack_err;
    assign stretch_err = q.str_err;

    // R1
    high_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RISE && q.chk && !scl_s) |=> (q.st == S_RISE || q.str_err));

    // R3
    stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RISE) |-> (q.uc <= STR_LIM));

    // R3
    stretch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.str_err) |-> (q.done && !q.scl_oe && !q.sda_oe));

    // R5
    ack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ack_err) |-> (q.st == S_SP_LO && q.scl_oe));

    // R6
    hs_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RISE && !q.chk) |=> (q.st != S_RISE));

    // R8
    sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.sda_oe != $past(q.sda_oe)) &&
         ($past(q.st) == S_B_LO || $past(q.st) == S_B_HI || $past(q.st) == S_ACK_W))
        |-> $past(q.scl_oe));
endmodule

// File: rtl/i2c_stretch_master.sv
module i2c_stretch_master #(
    parameter int QTR_DIV     = 312,
    parameter int US_DIV      = 125,
    parameter int STRETCH_MAX = 1000,
    parameter int SETTLE_US   = 10,
    parameter int ACK_MAX     = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic [7:0] wr_byte,
    input  logic       rd_nack,
    input  logic       hs_mode,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic       ack_err,
    output logic       stretch_err
);
    logic [1:0] line_s;

    i2cm_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(line_s)
    );

    i2cm_engine #(
        .QTR_DIV(QTR_DIV), .US_DIV(US_DIV), .STRETCH_MAX(STRETCH_MAX),
        .SETTLE_US(SETTLE_US), .ACK_MAX(ACK_MAX)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_byte(wr_byte), .rd_nack(rd_nack), .hs_mode(hs_mode),
        .scl_s(line_s[1]), .sda_s(line_s[0]),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
        .rd_byte(rd_byte), .ack_err(ack_err), .stretch_err(stretch_err)
    );
endmodule

// File: tb/sim_i2c_stretch_master.sv
`timescale 1ns/1ps
module sim_i2c_stretch_master;
    localparam int QD = 4;
    localparam int UD = 2;
    localparam int SMAX = 40;
    localparam int SET = 10;
    localparam int AMAX = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic [7:0] wr_byte = 8'd0;
    logic rd_nack = 1'b0;
    logic hs_mode = 1'b0;
    logic scl_oe, sda_oe, busy, done, ack_err, stretch_err;
    logic [7:0] rd_byte;

    logic s_scl_low = 1'b0;
    logic s_sda_low = 1'b0;
    wire scl_bus = !(scl_oe || s_scl_low);
    wire sda_bus = !(sda_oe || s_sda_low);

    always #4 clk = ~clk;

    i2c_stretch_master #(
        .QTR_DIV(QD), .US_DIV(UD), .STRETCH_MAX(SMAX), .SETTLE_US(SET), .ACK_MAX(AMAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .wr_byte(wr_byte),
        .rd_nack(rd_nack), .hs_mode(hs_mode), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .rd_byte(rd_byte),
        .ack_err(ack_err), .stretch_err(stretch_err)
    );

    // slave model
    int b = -1;
    int hold_cyc = 0;
    logic slv_write = 1'b0, slv_read = 1'b0, slv_ack = 1'b0;
    logic [7:0] slv_byte = 8'd0, rx = 8'd0;
    logic ack_bit = 1'b1;
    logic stop_seen = 1'b0;
    int hi_run = 0, last_hi = 0, min_hi = 9999;

    always @(negedge sda_bus) if (scl_bus) b = -1;
    always @(posedge sda_bus) if (scl_bus) stop_seen = 1'b1;
    always @(posedge scl_bus) begin
        if (b >= 0 && b < 8) rx = {rx[6:0], sda_bus};
        if (b == 8) ack_bit = sda_bus;
    end
    always @(negedge scl_bus) begin
        b = b + 1;
        if (b == 9) b = 0;
        if (b == 8) begin
            s_sda_low = slv_write && slv_ack;
            if (hold_cyc > 0) begin
                s_scl_low = 1'b1;
                repeat (hold_cyc) @(posedge clk);
                s_scl_low = 1'b0;
            end
        end else if (b >= 0) begin
            s_sda_low = slv_read ? !slv_byte[7-b] : 1'b0;
        end
    end
    always @(negedge clk) begin
        if (scl_bus) hi_run = hi_run + 1;
        else begin
            if (hi_run > 0) begin
                last_hi = hi_run;
                if (hi_run < min_hi) min_hi = hi_run;
            end
            hi_run = 0;
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c, input logic [7:0] d, input logic nk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c; wr_byte = d; rd_nack = nk;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // {op[1:0], data[7:0], flag, hold[7:0], hs, exp_ack_err, exp_str_err}
    localparam logic [21:0] VEC [7] = '{
        {2'd1, 8'hA5, 1'b1, 8'd0,   1'b0, 1'b0, 1'b0},
        {2'd1, 8'h3C, 1'b1, 8'd30,  1'b0, 1'b0, 1'b0},
        {2'd1, 8'h7E, 1'b0, 8'd0,   1'b0, 1'b1, 1'b0},
        {2'd2, 8'hC3, 1'b0, 8'd30,  1'b0, 1'b0, 1'b0},
        {2'd2, 8'h5A, 1'b1, 8'd0,   1'b1, 1'b0, 1'b0},
        {2'd1, 8'h81, 1'b1, 8'd60,  1'b1, 1'b0, 1'b0},
        {2'd1, 8'h11, 1'b1, 8'd200, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk(!scl_oe && !sda_oe, "R2 released after reset", {scl_oe, sda_oe}, 0);
        chk(!busy && !done, "R2 idle after reset", {busy, done}, 0);

        for (int i = 0; i < 7; i++) begin
            logic [1:0] op;
            logic [7:0] dat;
            logic fl, hs, ea, es;
            int hd;
            op = VEC[i][21:20]; dat = VEC[i][19:12]; fl = VEC[i][11];
            hd = int'(VEC[i][10:3]); hs = VEC[i][2]; ea = VEC[i][1]; es = VEC[i][0];
            slv_write = (op == 2'd1); slv_read = (op == 2'd2); slv_ack = fl;
            slv_byte = dat; hold_cyc = hd; hs_mode = hs;
            min_hi = 9999; stop_seen = 1'b0;
            issue(2'd0, 8'h00, 1'b0);
            issue(op, dat, fl);
            slv_read = 1'b0;
            // R5 R3 R11: error flags
            chk(ack_err == ea, "R5 ack_err flag", ack_err, ea);
            chk(stretch_err == es, "R3 R11 stretch_err flag", stretch_err, es);
            if (es) begin
                chk(!scl_oe && !sda_oe, "R3 lines released on abort", {scl_oe, sda_oe}, 0);
                wait (!s_scl_low);
                s_sda_low = 1'b0;
                repeat (4) @(negedge clk);
            end else begin
                // R10: high phases
                chk(min_hi >= 2*QD, "R10 min high phase", min_hi, 2*QD);
                if (op == 2'd2) begin
                    chk(rd_byte == dat, "R9 read byte", rd_byte, dat);
                    chk(ack_bit == fl, "R7 read ack bit", ack_bit, fl);
                end else if (!ea) begin
                    chk(rx == dat, "R8 written byte msb first", rx, dat);
                    chk(ack_bit == 1'b0, "R7 ack bit from slave", ack_bit, 0);
                    // R1 R4 R6: no high time counted during the hold
                    chk(last_hi >= SET*UD, "R1 R4 R6 ack high after hold", last_hi, SET*UD);
                end
                if (ea) begin
                    chk(stop_seen, "R5 stop after no ack", stop_seen, 1);
                end else begin
                    s_sda_low = 1'b0;
                    stop_seen = 1'b0;
                    issue(2'd3, 8'h00, 1'b0);
                    chk(stop_seen, "R11 stop command", stop_seen, 1);
                end
            end
        end

        // R11: recovery after stretch abort clears the flag
        slv_write = 1'b1; slv_ack = 1'b1; hold_cyc = 0; hs_mode = 1'b0; slv_byte = 8'h96;
        issue(2'd0, 8'h00, 1'b0);
        issue(2'd1, 8'h96, 1'b0);
        chk(!stretch_err && !ack_err, "R11 flags cleared", {stretch_err, ack_err}, 0);
        chk(rx == 8'h96, "R8 byte after recovery", rx, 8'h96);
        s_sda_low = 1'b0;
        issue(2'd3, 8'h00, 1'b0);
        chk(!scl_oe && !sda_oe && !busy, "R2 released after stop", {scl_oe, sda_oe, busy}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule